// File: doc/BRIEF.md
# Single-Bit NAND Sector ECC Engine

This block produces and checks a single-error-correcting parity code for NAND flash sectors. A generator side has one parity context per chip select. After a restart, a context watches the bytes that flow to or from its chip. For every one of the 12 position bits of a data bit (9 bits of byte index, 3 bits of bit-in-byte), it keeps two parities: one over the data bits whose position bit is 1, and one over the data bits whose position bit is 0. A read of the context returns the 24-bit code. The "position bit is 1" set sits in the upper 12 bits and the complementary set in the lower 12. The whole code is inverted, so an erased sector (all ones) produces a code of all ones, which matches erased spare bytes. The code is meant to be stored least significant byte first.

The checker side takes a stored code and a freshly computed code, and forms their XOR as a syndrome. It sorts the outcome into one of four classes: clean, correctable data bit, flipped bit inside the stored code, or uncorrectable. For a correctable data bit it reports the byte index and a one-hot mask. The sector buffer owner applies that correction with one XOR.

Top module: `ecc1b_engine`

## Requirements
- R1: After reset no context is accumulating, every `csDone` bit is 0, `codeValid` and `resValid` are 0, and a read of any context returns 24'hFFFFFF.
- R2: A code read out is the bitwise inverse of {upper set, lower set}. Upper bit k is the XOR of all accumulated data bits whose position (byte index × 8 + bit number) has bit k set. Lower bit k uses the data bits whose position bit k is clear.
- R3: A full sector of 8'hFF bytes yields the code 24'hFFFFFF.
- R4: A context stops after SECTOR_BYTES bytes and raises its `csDone` bit on the cycle after the last byte. Further bytes to that context change neither its code nor its done bit.
- R5: A read returns the code on `codeOut` with `codeValid` high exactly one cycle after `readReq`. It then clears that context to empty and stops its accumulation until the next restart.
- R6: Each chip select has its own context; bytes tagged for one chip select leave every other context unchanged.
- R7: A restart empties the context, clears its `csDone` bit and starts accumulation at byte index 0, even in the middle of a sector.
- R8: A syndrome of zero gives class 0 (clean). Results appear on `resValid`/`resClass` one cycle after `chkValid`.
- R9: When the upper 12 syndrome bits XOR the lower 12 bits equal 12'hFFF, the class is 1 (data fix). `fixIndex` is syndrome bits 23:15, and `fixMask` has a single 1 at the bit number given by syndrome bits 14:12.
- R10: A syndrome that passes the R9 test but whose index is not below SECTOR_BYTES gives class 3 (uncorrectable).
- R11: A syndrome with exactly one bit set gives class 2 (code bit), with `fixIndex` and `fixMask` zero.
- R12: Any other non-zero syndrome gives class 3. In every class other than 1, `fixIndex` and `fixMask` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restartValid | input | 1 | Restart the context named by restartCs |
| restartCs | input | CSW | Chip select to restart |
| byteValid | input | 1 | A sector byte is present |
| byteCs | input | CSW | Chip select owning the byte |
| byteData | input | 8 | Sector byte |
| readReq | input | 1 | Read and clear a context |
| readCs | input | CSW | Context to read |
| codeValid | output | 1 | codeOut holds a read result |
| codeOut | output | CODEW | Inverted packed code |
| csDone | output | NUM_CS | Per-context full-sector flag |
| chkValid | input | 1 | Compare storedCode against calcCode |
| storedCode | input | CODEW | Code read back from the spare area |
| calcCode | input | CODEW | Code computed over the data just read |
| resValid | output | 1 | Decode result valid |
| resClass | output | 2 | 0 clean, 1 data fix, 2 code bit, 3 uncorrectable |
| fixIndex | output | IDXW | Byte to correct |
| fixMask | output | 8 | Bit mask to XOR into that byte |

## Verification
A byte updates its context at the clock edge that samples it. `csDone` therefore rises on the edge that takes in the final byte and can be seen after that edge. A read result and a decode result are each one register deep, so they are due on the edge after the request. The bench drives every request half a cycle before an edge and samples at the following falling edge, which is exactly one register stage later. The context model and the syndrome expectations in the bench are computed from the position-bit definition, bit by bit. A second instance with a sector size that is not a power of two exercises the out-of-range index rule.

// File: rtl/ecc1b_pkg.sv
package ecc1b_pkg;

  typedef enum logic [1:0] {
    ECC_CLEAN    = 2'd0,
    ECC_FIX_DATA = 2'd1,
    ECC_FIX_CODE = 2'd2,
    ECC_UNCORR   = 2'd3
  } eccClass_t;

  // per-context strobes issued by control to the parity datapath
  typedef struct packed {
    logic clear;
    logic accum;
    logic capture;
  } ctxStrobe_t;

endpackage

// File: rtl/ecc1b_ctrl.sv
module ecc1b_ctrl
  import ecc1b_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int NUM_CS       = 4,
  localparam int IDXW = $clog2(SECTOR_BYTES),
  localparam int CSW  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restartValid,
  input  logic [CSW-1:0]    restartCs,
  input  logic              byteValid,
  input  logic [CSW-1:0]    byteCs,
  input  logic              readReq,
  input  logic [CSW-1:0]    readCs,
  output ctxStrobe_t        strobe [NUM_CS],
  output logic [IDXW-1:0]   byteIdx,
  output logic [NUM_CS-1:0] csDone
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(SECTOR_BYTES - 1);

  logic [IDXW-1:0] cnt [NUM_CS];
  logic [NUM_CS-1:0] active;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ctx
    logic restartHit, readHit, byteHit;

    assign restartHit = restartValid && (restartCs == CSW'(g));
    assign readHit    = readReq && (readCs == CSW'(g));
    assign byteHit    = byteValid && (byteCs == CSW'(g)) && active[g];

    always_comb begin
      strobe[g].clear   = restartHit || readHit;
      strobe[g].capture = readHit;
      strobe[g].accum   = byteHit && !restartHit && !readHit;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        active[g] <= 1'b0;
        cnt[g]    <= '0;
        csDone[g] <= 1'b0;
      end else if (restartHit) begin
        active[g] <= 1'b1;
        cnt[g]    <= '0;
        csDone[g] <= 1'b0;
      end else if (readHit) begin
        active[g] <= 1'b0;
        cnt[g]    <= '0;
      end else if (byteHit) begin
        if (cnt[g] == LAST_IDX) begin
          active[g] <= 1'b0;
          csDone[g] <= 1'b1;
          cnt[g]    <= '0;
        end else begin
          cnt[g] <= cnt[g] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    byteIdx = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (byteCs == CSW'(i)) byteIdx = cnt[i];
    end
  end

endmodule

// File: rtl/ecc1b_dpath.sv
module ecc1b_dpath
  import ecc1b_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int NUM_CS       = 4,
  localparam int IDXW  = $clog2(SECTOR_BYTES),
  localparam int POSW  = IDXW + 3,
  localparam int CODEW = 2 * POSW,
  localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctxStrobe_t       strobe [NUM_CS],
  input  logic [IDXW-1:0]  byteIdx,
  input  logic [7:0]       byteData,
  input  logic [CSW-1:0]   readCs,
  output logic             codeValid,
  output logic [CODEW-1:0] codeOut
);

  logic [POSW-1:0] hiPar [NUM_CS];
  logic [POSW-1:0] loPar [NUM_CS];
  logic [POSW-1:0] hiInc, loInc;
  logic            bytePar;
  logic            anyCapture;

  assign bytePar = ^byteData;

  // bit-in-byte position bits: split the byte by bit number
  always_comb begin
    hiInc[2:0] = '0;
    loInc[2:0] = '0;
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < 8; b++) begin
        if (((b >> k) & 1) == 1) hiInc[k] = hiInc[k] ^ byteData[b];
        else                     loInc[k] = loInc[k] ^ byteData[b];
      end
    end
  end

  // byte-index position bits: whole-byte parity steered by the index
  for (genvar j = 0; j < IDXW; j++) begin : g_idx
    assign hiInc[3+j] = byteIdx[j]  & bytePar;
    assign loInc[3+j] = ~byteIdx[j] & bytePar;
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ctx
    always_ff @(posedge clk) begin
      if (!rst_n || strobe[g].clear) begin
        hiPar[g] <= '0;
        loPar[g] <= '0;
      end else if (strobe[g].accum) begin
        hiPar[g] <= hiPar[g] ^ hiInc;
        loPar[g] <= loPar[g] ^ loInc;
      end
    end
  end

  always_comb begin
    anyCapture = 1'b0;
    for (int i = 0; i < NUM_CS; i++) anyCapture = anyCapture | strobe[i].capture;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      codeValid <= 1'b0;
      codeOut   <= '0;
    end else begin
      codeValid <= anyCapture;
      if (anyCapture) codeOut <= ~{hiPar[readCs], loPar[readCs]};
    end
  end

endmodule

// File: rtl/ecc1b_decode.sv
module ecc1b_decode
  import ecc1b_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int IDXW  = $clog2(SECTOR_BYTES),
  localparam int POSW  = IDXW + 3,
  localparam int CODEW = 2 * POSW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chkValid,
  input  logic [CODEW-1:0] storedCode,
  input  logic [CODEW-1:0] calcCode,
  output logic             resValid,
  output logic [1:0]       resClass,
  output logic [IDXW-1:0]  fixIndex,
  output logic [7:0]       fixMask
);

  logic [CODEW-1:0] syn;
  logic [POSW-1:0]  synHi, synLo;
  logic [IDXW-1:0]  idxNext;
  logic [2:0]       bitNext;
  eccClass_t        clsNext;
  logic             inRange;

  assign syn     = storedCode ^ calcCode;
  assign synHi   = syn[CODEW-1:POSW];
  assign synLo   = syn[POSW-1:0];
  assign bitNext = synHi[2:0];
  assign idxNext = synHi[POSW-1:3];
  assign inRange = ({1'b0, idxNext} < (IDXW+1)'(SECTOR_BYTES));

  always_comb begin
    if (syn == '0)                          clsNext = ECC_CLEAN;
    else if ((synHi ^ synLo) == '1)         clsNext = inRange ? ECC_FIX_DATA : ECC_UNCORR;
    else if ($countones(syn) == 1)          clsNext = ECC_FIX_CODE;
    else                                    clsNext = ECC_UNCORR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resValid <= 1'b0;
      resClass <= 2'd0;
      fixIndex <= '0;
      fixMask  <= '0;
    end else begin
      resValid <= chkValid;
      if (chkValid) begin
        resClass <= clsNext;
        fixIndex <= (clsNext == ECC_FIX_DATA) ? idxNext : '0;
        fixMask  <= (clsNext == ECC_FIX_DATA) ? (8'd1 << bitNext) : 8'd0;
      end
    end
  end

endmodule

// File: rtl/ecc1b_engine.sv
module ecc1b_engine
  import ecc1b_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int NUM_CS       = 4,
  localparam int IDXW  = $clog2(SECTOR_BYTES),
  localparam int POSW  = IDXW + 3,
  localparam int CODEW = 2 * POSW,
  localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restartValid,
  input  logic [CSW-1:0]    restartCs,
  input  logic              byteValid,
  input  logic [CSW-1:0]    byteCs,
  input  logic [7:0]        byteData,
  input  logic              readReq,
  input  logic [CSW-1:0]    readCs,
  output logic              codeValid,
  output logic [CODEW-1:0]  codeOut,
  output logic [NUM_CS-1:0] csDone,
  input  logic              chkValid,
  input  logic [CODEW-1:0]  storedCode,
  input  logic [CODEW-1:0]  calcCode,
  output logic              resValid,
  output logic [1:0]        resClass,
  output logic [IDXW-1:0]   fixIndex,
  output logic [7:0]        fixMask
);

  ctxStrobe_t      strobe [NUM_CS];
  logic [IDXW-1:0] byteIdx;

  ecc1b_ctrl #(.SECTOR_BYTES(SECTOR_BYTES), .NUM_CS(NUM_CS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .restartValid(restartValid), .restartCs(restartCs),
    .byteValid(byteValid), .byteCs(byteCs),
    .readReq(readReq), .readCs(readCs),
    .strobe(strobe), .byteIdx(byteIdx), .csDone(csDone)
  );

  ecc1b_dpath #(.SECTOR_BYTES(SECTOR_BYTES), .NUM_CS(NUM_CS)) u_dpath (
    .clk(clk), .rst_n(rst_n),
    .strobe(strobe), .byteIdx(byteIdx), .byteData(byteData),
    .readCs(readCs), .codeValid(codeValid), .codeOut(codeOut)
  );

  ecc1b_decode #(.SECTOR_BYTES(SECTOR_BYTES)) u_decode (
    .clk(clk), .rst_n(rst_n),
    .chkValid(chkValid), .storedCode(storedCode), .calcCode(calcCode),
    .resValid(resValid), .resClass(resClass),
    .fixIndex(fixIndex), .fixMask(fixMask)
  );

endmodule

// File: rtl/ecc1b_chk.sv
module ecc1b_chk #(
  parameter int SECTOR_BYTES = 512,
  parameter int NUM_CS       = 4,
  localparam int IDXW = $clog2(SECTOR_BYTES),
  localparam int CSW  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restartValid,
  input logic [CSW-1:0]    restartCs,
  input logic              byteValid,
  input logic [CSW-1:0]    byteCs,
  input logic              readReq,
  input logic              codeValid,
  input logic [NUM_CS-1:0] csDone,
  input logic              chkValid,
  input logic              resValid,
  input logic [1:0]        resClass,
  input logic [IDXW-1:0]   fixIndex,
  input logic [7:0]        fixMask
);

  // R5: read result one cycle after the request, never otherwise
  assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    readReq |=> codeValid);
  assert_no_spurious_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !readReq |=> !codeValid);

  // R8: decode result one cycle after the compare request
  assert_decode_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chkValid |=> resValid);
  assert_no_spurious_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chkValid |=> !resValid);

  // R9: a data fix names exactly one bit of a byte inside the sector
  assert_fix_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resClass == 2'd1) |-> $onehot0(fixMask) && fixMask != 8'd0);
  // R10: the byte to correct is always inside the sector
  assert_fix_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resClass == 2'd1) |-> ({1'b0, fixIndex} < (IDXW+1)'(SECTOR_BYTES)));
  // R12: no correction outputs for any other class
  assert_no_fix_otherwise_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resClass != 2'd1) |-> (fixMask == 8'd0 && fixIndex == '0));

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    // R4: done only rises on a byte for that context
    assert_done_by_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(csDone[g]) |-> ($past(byteValid) && $past(byteCs) == CSW'(g)));
    // R7: restart clears the done flag
    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (restartValid && restartCs == CSW'(g)) |=> !csDone[g]);
  end

endmodule

bind ecc1b_engine ecc1b_chk #(.SECTOR_BYTES(SECTOR_BYTES), .NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .restartValid(restartValid), .restartCs(restartCs),
  .byteValid(byteValid), .byteCs(byteCs),
  .readReq(readReq), .codeValid(codeValid), .csDone(csDone),
  .chkValid(chkValid), .resValid(resValid), .resClass(resClass),
  .fixIndex(fixIndex), .fixMask(fixMask)
);

// File: tb/tb_ecc1b_engine.sv
module tb_ecc1b_engine;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        restartValid = 0;
  logic [1:0]  restartCs = 0;
  logic        byteValid = 0;
  logic [1:0]  byteCs = 0;
  logic [7:0]  byteData = 0;
  logic        readReq = 0;
  logic [1:0]  readCs = 0;
  logic        codeValid;
  logic [23:0] codeOut;
  logic [3:0]  csDone;
  logic        chkValid = 0;
  logic [23:0] storedCode = 0;
  logic [23:0] calcCode = 0;
  logic        resValid;
  logic [1:0]  resClass;
  logic [8:0]  fixIndex;
  logic [7:0]  fixMask;

  ecc1b_engine dut (
    .clk(clk), .rst_n(rst_n),
    .restartValid(restartValid), .restartCs(restartCs),
    .byteValid(byteValid), .byteCs(byteCs), .byteData(byteData),
    .readReq(readReq), .readCs(readCs),
    .codeValid(codeValid), .codeOut(codeOut), .csDone(csDone),
    .chkValid(chkValid), .storedCode(storedCode), .calcCode(calcCode),
    .resValid(resValid), .resClass(resClass),
    .fixIndex(fixIndex), .fixMask(fixMask)
  );

  // second instance: sector size that leaves index codes out of range
  logic        chk2Valid = 0;
  logic [23:0] stored2 = 0;
  logic        code2Valid, res2Valid;
  logic [23:0] code2Out;
  logic [3:0]  done2;
  logic [1:0]  res2Class;
  logic [8:0]  fix2Index;
  logic [7:0]  fix2Mask;

  ecc1b_engine #(.SECTOR_BYTES(384)) dut2 (
    .clk(clk), .rst_n(rst_n),
    .restartValid(1'b0), .restartCs(2'd0),
    .byteValid(1'b0), .byteCs(2'd0), .byteData(8'd0),
    .readReq(1'b0), .readCs(2'd0),
    .codeValid(code2Valid), .codeOut(code2Out), .csDone(done2),
    .chkValid(chk2Valid), .storedCode(stored2), .calcCode(24'd0),
    .resValid(res2Valid), .resClass(res2Class),
    .fixIndex(fix2Index), .fixMask(fix2Mask)
  );

  int nTests = 0;
  int nFail  = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] patByte(input int kind, input int i);
    case (kind)
      0: return 8'((i * 37 + 11) & 255);
      1: return 8'hFF;
      2: return (i == 7) ? 8'h04 : 8'h00;
      default: return (i == 0) ? 8'h01 : 8'h00;
    endcase
  endfunction

  // code per the position-bit definition, one data bit at a time
  function automatic logic [23:0] modelCode(input int kind, input int n);
    logic [11:0] hi = '0;
    logic [11:0] lo = '0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = patByte(kind, i);
      for (int b = 0; b < 8; b++) begin
        if (d[b]) begin
          logic [11:0] pos = 12'(i * 8 + b);
          for (int k = 0; k < 12; k++) begin
            if (pos[k]) hi[k] = ~hi[k];
            else        lo[k] = ~lo[k];
          end
        end
      end
    end
    return ~{hi, lo};
  endfunction

  task automatic sendByte(input logic [1:0] cs, input logic [7:0] d);
    @(negedge clk);
    byteValid = 1; byteCs = cs; byteData = d;
    @(negedge clk);
    byteValid = 0;
  endtask

  task automatic restart(input logic [1:0] cs);
    @(negedge clk);
    restartValid = 1; restartCs = cs;
    @(negedge clk);
    restartValid = 0;
  endtask

  task automatic readCode(input logic [1:0] cs, output logic [23:0] code, output logic vld);
    @(negedge clk);
    readReq = 1; readCs = cs;
    @(negedge clk);
    readReq = 0;
    code = codeOut; vld = codeValid;
  endtask

  // {stored, calc, class, index, mask}
  localparam logic [66:0] VEC [10] = '{
    {24'h000000, 24'h000000, 2'd0, 9'd0,   8'h00},  // R8
    {24'h123456, 24'h123456, 2'd0, 9'd0,   8'h00},  // R8
    {24'h02BFD4, 24'h000000, 2'd1, 9'd5,   8'h08},  // R9
    {24'hFFF000, 24'h000000, 2'd1, 9'd511, 8'h80},  // R9
    {24'h000FFF, 24'h000000, 2'd1, 9'd0,   8'h01},  // R9
    {24'hA5A5A5, 24'hA71A71, 2'd1, 9'd5,   8'h08},  // R9
    {24'h000100, 24'h000000, 2'd2, 9'd0,   8'h00},  // R11
    {24'h800000, 24'h000000, 2'd2, 9'd0,   8'h00},  // R11
    {24'h000003, 24'h000000, 2'd3, 9'd0,   8'h00},  // R12
    {24'hC0FFEE, 24'h123456, 2'd3, 9'd0,   8'h00}   // R12
  };

  task automatic runAll();
    logic [23:0] code;
    logic vld;
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 done", 32'(csDone), 32'h0);
    check("R1 codeValid", 32'(codeValid), 32'h0);
    check("R1 resValid", 32'(resValid), 32'h0);
    readCode(2'd0, code, vld);
    check("R1 empty code", 32'(code), 32'hFFFFFF);
    check("R5 valid", 32'(vld), 32'h1);
    @(negedge clk);
    check("R5 valid drops", 32'(codeValid), 32'h0);

    // R2/R4: full sector of a varied pattern on cs0
    restart(2'd0);
    for (int i = 0; i < 511; i++) sendByte(2'd0, patByte(0, i));
    check("R4 not done early", 32'(csDone[0]), 32'h0);
    sendByte(2'd0, patByte(0, 511));
    check("R4 done", 32'(csDone[0]), 32'h1);
    for (int i = 0; i < 5; i++) sendByte(2'd0, 8'h5A);
    check("R4 done held", 32'(csDone[0]), 32'h1);
    readCode(2'd0, code, vld);
    check("R2 R4 sector code", 32'(code), 32'(modelCode(0, 512)));
    // R5: read cleared the context and halted it
    sendByte(2'd0, 8'h3C);
    readCode(2'd0, code, vld);
    check("R5 cleared", 32'(code), 32'hFFFFFF);
    check("R4 done after read", 32'(csDone[0]), 32'h1);
    restart(2'd0);
    check("R7 done cleared", 32'(csDone[0]), 32'h0);

    // R3: erased sector on cs1
    restart(2'd1);
    for (int i = 0; i < 512; i++) sendByte(2'd1, 8'hFF);
    readCode(2'd1, code, vld);
    check("R3 erased", 32'(code), 32'hFFFFFF);

    // R6: interleaved contexts
    restart(2'd1);
    restart(2'd2);
    for (int i = 0; i < 20; i++) begin
      sendByte(2'd1, patByte(1, i));
      sendByte(2'd2, patByte(2, i));
    end
    readCode(2'd1, code, vld);
    check("R6 cs1", 32'(code), 32'(modelCode(1, 20)));
    readCode(2'd2, code, vld);
    check("R6 cs2", 32'(code), 32'(modelCode(2, 20)));
    readCode(2'd3, code, vld);
    check("R6 cs3 untouched", 32'(code), 32'hFFFFFF);

    // R7: restart mid-stream
    restart(2'd3);
    for (int i = 0; i < 10; i++) sendByte(2'd3, 8'h55);
    restart(2'd3);
    sendByte(2'd3, 8'h01);
    readCode(2'd3, code, vld);
    check("R7 restart", 32'(code), 32'(modelCode(3, 1)));

    // R8..R12: syndrome decode vectors
    foreach (VEC[v]) begin
      @(negedge clk);
      chkValid = 1; storedCode = VEC[v][66:43]; calcCode = VEC[v][42:19];
      @(negedge clk);
      chkValid = 0;
      check("R8 resValid", 32'(resValid), 32'h1);
      check($sformatf("R8-R12 class vec%0d", v), 32'(resClass), 32'(VEC[v][18:17]));
      check($sformatf("R9 index vec%0d", v), 32'(fixIndex), 32'(VEC[v][16:8]));
      check($sformatf("R9 mask vec%0d", v), 32'(fixMask), 32'(VEC[v][7:0]));
    end

    // R10: index beyond a 384-byte sector
    @(negedge clk);
    chk2Valid = 1; stored2 = 24'hC8237D;   // byte 400, bit 2
    @(negedge clk);
    check("R10 out of range", 32'(res2Class), 32'h3);
    check("R10 no mask", 32'(fix2Mask), 32'h0);
    stored2 = 24'hBF9406;                  // byte 383, bit 1
    @(negedge clk);
    chk2Valid = 0;
    check("R10 last byte class", 32'(res2Class), 32'h1);
    check("R10 last byte index", 32'(fix2Index), 32'd383);
    check("R10 last byte mask", 32'(fix2Mask), 32'h02);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        nTests++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule